// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block divides a high-rate input clock by a programmable integer modulus using the pulse-swallowing method. An 11-bit modulus word is split into a main count M (bits [10:3]) and a swallow count A (bits [2:0]). A prescaler divides by 9 while the swallow counter is non-zero and by 8 once it has run out. The main counter steps once per prescaler period and ends the division cycle. The total ratio is 8·M + A input clocks per output pulse.

The word is taken only at a cycle boundary, so a cycle in progress keeps the ratio it started with. A combinational flag reports a word that cannot be realised (M = 0, or A greater than M). Such a word is never loaded: the divider sits idle and produces no pulses until a legal word is present.

Top module: `fbdiv_top`

## Requirements
- R1: With `div_word[10:3]` = M and `div_word[2:0]` = A, consecutive `out_pulse` assertions are exactly 8·M + A input clocks apart.
- R2: With A = 0 the spacing between pulses is exactly 8·M clocks, a plain multiple of the prescaler base, and the prescaler count never exceeds 8.
- R3: Each output pulse is high for exactly one input clock.
- R4: `illegal` is high, combinationally from `div_word`, exactly when M = 0 or A > M.
- R5: A word with `illegal` high is never loaded. If one is present at a cycle boundary, the pulse for the completed cycle is still given and then no further pulses appear. Once a legal word is applied, the first pulse follows 8·M + A + 1 clocks later.
- R6: `div_word` is sampled only at a cycle boundary. Changing it mid-cycle leaves the length of the running cycle unchanged, and the new ratio applies from the next cycle.
- R7: While `rst_n` is low `out_pulse` is low. After reset is released with a legal word applied, the first pulse is seen 8·M + A + 1 clocks later.
- R8: The extreme moduli 8 (M=1, A=0), 9 (M=1, A=1), 56 and 2047 (M=255, A=7) are produced exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_word | input | 11 | Modulus word: [10:3] main count M, [2:0] swallow count A |
| out_pulse | output | 1 | One-clock pulse at the end of every division cycle |
| illegal | output | 1 | High when the applied word cannot be realised |

## Verification
The assertions rely on one property of the loaded setting: A never exceeds M. From that follows the invariant that the remaining swallow count never exceeds the remaining main count. The invariant holds only because the load path refuses words flagged illegal. The stimulus draws random M and A and keeps the illegal ones for the flag checks. Before a word is used for period measurement, the bench clamps it into the legal region, or applies it on purpose as an illegal word to test the idle behaviour. Words change only at the falling edge, away from the boundary edge that samples them.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int unsigned PRE_N  = 8;
  localparam int unsigned A_W    = $clog2(PRE_N);
  localparam int unsigned M_W    = 8;
  localparam int unsigned WORD_W = M_W + A_W;

  // total division ratio for main count m, swallow count a, prescaler base n
  function automatic int unsigned fb_ratio(int unsigned m, int unsigned a, int unsigned n);
    return m * n + a;
  endfunction

  // a setting is realisable when the main count is non-zero and covers the swallow count
  function automatic logic fb_ok(int unsigned m, int unsigned a);
    return (m != 0) && (a <= m);
  endfunction
endpackage

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler #(
  parameter int unsigned PRE_N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic swallow,
  output logic tc
);
  localparam int unsigned CW = $clog2(PRE_N + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  // period of PRE_N+1 while swallowing, PRE_N otherwise
  assign limit = swallow ? CW'(PRE_N) : CW'(PRE_N - 1);
  assign tc    = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (restart || tc) cnt <= '0;
    else if (run)           cnt <= cnt + CW'(1);
  end

  // R2
  pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(PRE_N));
endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow #(
  parameter int unsigned A_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] load_val,
  input  logic           tc,
  output logic [A_W-1:0] a_rem,
  output logic           swallow
);
  assign swallow = (a_rem != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               a_rem <= '0;
    else if (load)            a_rem <= load_val;
    else if (tc && swallow)   a_rem <= a_rem - A_W'(1);
  end

  // R1
  swallow_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (a_rem <= $past(a_rem)));
endmodule

// File: rtl/fbdiv_main.sv
module fbdiv_main #(
  parameter int unsigned M_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [M_W-1:0] load_val,
  input  logic           tc,
  output logic [M_W-1:0] m_rem,
  output logic           last
);
  assign last = (m_rem == M_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     m_rem <= '0;
    else if (load)  m_rem <= load_val;
    else if (tc)    m_rem <= m_rem - M_W'(1);
  end

  // R6
  main_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tc) |=> $stable(m_rem));
endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top #(
  parameter int unsigned M_W   = fbdiv_pkg::M_W,
  parameter int unsigned PRE_N = fbdiv_pkg::PRE_N
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [M_W+$clog2(PRE_N)-1:0]     div_word,
  output logic                             out_pulse,
  output logic                             illegal
);
  localparam int unsigned A_W    = $clog2(PRE_N);
  localparam int unsigned WORD_W = M_W + A_W;

  logic [M_W-1:0] word_m;
  logic [A_W-1:0] word_a;
  logic           idle_q;
  logic           run;
  logic           pre_tc;
  logic           swallow;
  logic           m_last;
  logic           cyc_end;
  logic           load;
  logic           restart;
  logic [A_W-1:0] a_rem;
  logic [M_W-1:0] m_rem;

  assign word_m  = div_word[WORD_W-1:A_W];
  assign word_a  = div_word[A_W-1:0];
  assign illegal = !fbdiv_pkg::fb_ok(32'(word_m), 32'(word_a));

  assign run     = !idle_q;
  assign cyc_end = pre_tc && m_last;
  assign load    = !illegal && (idle_q || cyc_end);
  assign restart = load || cyc_end;

  fbdiv_prescaler #(.PRE_N(PRE_N)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .swallow(swallow), .tc(pre_tc)
  );

  fbdiv_swallow #(.A_W(A_W)) u_swl (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(word_a),
    .tc(pre_tc), .a_rem(a_rem), .swallow(swallow)
  );

  fbdiv_main #(.M_W(M_W)) u_main (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(word_m),
    .tc(pre_tc), .m_rem(m_rem), .last(m_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q    <= 1'b1;
      out_pulse <= 1'b0;
    end else begin
      out_pulse <= cyc_end;
      if (idle_q || cyc_end) idle_q <= illegal;
    end
  end

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_pulse |=> !out_pulse);

  // R1
  swallow_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (32'(a_rem) <= 32'(m_rem)));

  // R1
  main_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (m_rem != '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && illegal) |=> idle_q);
endmodule

// File: tb/sim_fbdiv_top.sv
module sim_fbdiv_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] div_word = 11'h0;
  logic        out_pulse;
  logic        illegal;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fbdiv_top u0 (.clk(clk), .rst_n(rst_n), .div_word(div_word),
                .out_pulse(out_pulse), .illegal(illegal));

  function automatic int expect_len(logic [10:0] w);
    int mm = int'(w >> 3);
    int aa = int'(w & 11'd7);
    return aa + mm * 8;
  endfunction

  function automatic bit expect_bad(logic [10:0] w);
    int mm = int'(w >> 3);
    int aa = int'(w & 11'd7);
    return (mm == 0) || (aa > mm);
  endfunction

  function automatic logic [10:0] mk(int mm, int aa);
    return {8'(mm), 3'(aa)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts falling edges until out_pulse is seen; -1 when limit passes
  task automatic to_pulse(input int limit, output int n);
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!out_pulse && k < limit);
    n = out_pulse ? k : -1;
  endtask

  // apply word at a pulse, skip the old cycle, measure the new one, check width
  task automatic measure(logic [10:0] w, string req);
    int n;
    div_word = w;
    to_pulse(4200, n);
    to_pulse(4200, n);
    chk(n == expect_len(w), req, n, expect_len(w));
    @(negedge clk);
    chk(out_pulse == 1'b0, "R3 pulse width", int'(out_pulse), 0);
    to_pulse(4200, n);
  endtask

  initial begin
    int n;
    process::self().srandom(32'h5eed_0377);

    // R7 reset
    div_word = mk(1, 0);
    repeat (5) @(negedge clk);
    chk(out_pulse == 1'b0, "R7 reset output", int'(out_pulse), 0);
    rst_n = 1'b1;
    to_pulse(100, n);
    chk(n == 9, "R7 first pulse latency", n, 9);

    // R8 extremes
    measure(mk(1, 0), "R8 modulus 8");
    measure(mk(1, 1), "R8 modulus 9");
    measure(mk(7, 0), "R8 modulus 56");
    measure(mk(255, 7), "R8 modulus 2047");

    // R2 A=0 multiples of 8
    measure(mk(5, 0), "R2 A zero M5");
    measure(mk(100, 0), "R2 A zero M100");

    // R1 directed
    measure(mk(7, 7), "R1 A equal M");
    measure(mk(3, 2), "R1 modulus 26");

    // R4 flag over random words, combinational
    for (int i = 0; i < 40; i++) begin
      logic [10:0] w = 11'($urandom);
      if (i % 4 == 0) w = mk(int'($urandom % 8), int'($urandom % 8));
      div_word = w;
      #1;
      chk(illegal == expect_bad(w), "R4 illegal flag", int'(illegal), int'(expect_bad(w)));
    end
    div_word = mk(0, 0);
    #1;
    chk(illegal == 1'b1, "R4 M zero", int'(illegal), 1);
    div_word = mk(2, 3);
    #1;
    chk(illegal == 1'b1, "R4 A above M", int'(illegal), 1);

    // resync onto a known legal period
    div_word = mk(4, 1);
    to_pulse(4200, n);
    to_pulse(4200, n);

    // R6 mid-cycle change
    repeat (3) @(negedge clk);
    div_word = mk(9, 5);
    to_pulse(4200, n);
    chk(n == 33 - 3, "R6 running cycle kept", n, 30);
    to_pulse(4200, n);
    chk(n == 77, "R6 new ratio next cycle", n, 77);

    // R5 illegal word: finish cycle, then silence, then resume
    div_word = mk(2, 5);
    to_pulse(4200, n);
    chk(n == 77, "R5 completed cycle pulse", n, 77);
    to_pulse(3000, n);
    chk(n == -1, "R5 no pulse while illegal", n, -1);
    div_word = mk(0, 0);
    to_pulse(500, n);
    chk(n == -1, "R5 no pulse M zero", n, -1);
    div_word = mk(6, 3);
    to_pulse(4200, n);
    chk(n == 52, "R5 resume latency", n, 52);

    // R1 random legal words
    for (int i = 0; i < 15; i++) begin
      int mm = int'($urandom % 128);
      int aa = int'($urandom % 8);
      if (mm == 0) mm = 1;
      if (aa > mm) aa = mm;
      measure(mk(mm, aa), "R1 random ratio");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule